// File: doc/BRIEF.md
# Four-Stage Read-After-Write Interlock with Forwarding

This block is an in-order, four-stage pipeline built around one piece of architectural state. The state is a small register array of `DEPTH` entries; with `DEPTH` set to 1 it becomes a single register. The first stage reads the state and the fourth stage writes it. The block holds the transaction bookkeeping for the later stages: the valid bit, the write-enable and the write index. From that bookkeeping it works out when a younger read would see a stale value.

When it finds such a hazard, it either bypasses the pending value from a forwarding tap or raises `stall`. A stall makes the producer hold the same transaction at the inputs, and the block puts an empty slot into stage 2. The two forwarding taps are chosen by parameters. One sits on the stage-4 write data. The other is the stage-3 mux output, or only the pass-through leg of that mux. The datapath is kept deliberately trivial so that its results can be checked. Each transaction computes a value, optionally writes it back, and the observed write stream must equal the one produced by executing the transactions one at a time.

Top module: `raw_fwd_pipe`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `cm_valid` is 0 and every state entry is 0; with `in_valid` low, `stall` is 0.
- R2: Take each accepted transaction in order. Its operand is r = the current state entry at `rd_idx` when `rd_en` is 1, otherwise 0. It computes x = r + `k` modulo 2^DW. It writes when `wr_req` is 1 and either `cond` is 0 or x is nonzero. The written data is x rotated left by one bit when `sel` is 1, and x when `sel` is 0. Three cycles after acceptance, `cm_valid`, `cm_we`, `cm_idx` and `cm_data` show this result, and it must match sequential execution.
- R3: `stall` is 0 whenever `in_valid` or `rd_en` is 0.
- R4: An in-flight write to an index other than `rd_idx` never causes a stall.
- R5: A valid transaction in stage 2 whose write index equals `rd_idx` causes a stall. This holds even if it later turns out not to write, because its write-enable is only known in stage 3.
- R6: When stage 2 holds such a matching transaction, no value is forwarded from stage 3 or stage 4, even if those stages also hold matching writes.
- R7: With `FWD_S4` set, a matching write in stage 4 alone, with no nearer matching writer, is forwarded without a stall.
- R8: With `FWD_S3_MUX` clear and `FWD_S3_PASS` set, a matching stage-3 write is forwarded only when its `sel` is 0; with `sel` 1 the read stalls.
- R9: A stalled cycle sends an empty slot down the pipeline. Exactly three cycles later `cm_valid` is 0 for that slot, while the older transactions keep committing.
- R10: `stall` equals the unforwarded hazard: a matching writer in stages 2 to 4, less the enabled forward triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A transaction is presented to stage 1 |
| rd_en | input | 1 | The transaction needs the state value |
| rd_idx | input | IW | Entry to read |
| wr_req | input | 1 | The transaction asks to write |
| wr_idx | input | IW | Entry to write |
| cond | input | 1 | Suppress the write when the result is zero |
| sel | input | 1 | Stage-3 mux select: 1 rotates the result |
| k | input | DW | Operand added to the read value |
| stall | output | 1 | Hold the current inputs; stage 2 receives a bubble |
| cm_valid | output | 1 | Stage 4 holds a transaction |
| cm_we | output | 1 | That transaction writes the state |
| cm_idx | output | IW | Entry being written |
| cm_data | output | DW | Data being written |

## Verification
The bench goes after back-to-back dependences at each distance. At distance one, a design that trusted the unknown stage-2 enable would let a read through before a write that does happen, and the wrong data would show up in the commit stream. At distance two, the mux-select gating matters: forwarding the unrotated value while `sel` is 1 would commit a wrong sum. The bench also covers two writers to the same entry in flight at once; picking the older one would commit stale data. Stalls are checked too: an idle read, a read of a different entry, or a bubble that is not cleared would all show up as a `stall` or `cm_valid` mismatch against the one-at-a-time model.

// File: rtl/raw_fwd_pipe.sv
module raw_fwd_pipe #(
  parameter int DW = 8,
  parameter int DEPTH = 4,
  parameter bit FWD_S4 = 1'b1,
  parameter bit FWD_S3_MUX = 1'b0,
  parameter bit FWD_S3_PASS = 1'b1,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  input  logic          wr_req,
  input  logic [IW-1:0] wr_idx,
  input  logic          cond,
  input  logic          sel,
  input  logic [DW-1:0] k,
  output logic          stall,
  output logic          cm_valid,
  output logic          cm_we,
  output logic [IW-1:0] cm_idx,
  output logic [DW-1:0] cm_data
);
  logic [DW-1:0] mem [DEPTH];

  logic          v2, wq2, cd2, sl2;
  logic [IW-1:0] idx2;
  logic [DW-1:0] r2, k2;
  logic          v3, wq3, cd3, sl3;
  logic [IW-1:0] idx3;
  logic [DW-1:0] x3;
  logic          v4, we4;
  logic [IW-1:0] idx4;
  logic [DW-1:0] wd4;

  logic          we3;
  logic [DW-1:0] wd3, rd_val, rd_mem;
  logic          m2, m3, m4, h2, h3, h4, f3, f4;

  assign we3 = wq3 & (~cd3 | (x3 != '0));
  assign wd3 = sl3 ? {x3[DW-2:0], x3[DW-1]} : x3;

  assign m2 = (DEPTH == 1) || (idx2 == rd_idx);
  assign m3 = (DEPTH == 1) || (idx3 == rd_idx);
  assign m4 = (DEPTH == 1) || (idx4 == rd_idx);

  assign h2 = v2 & m2;
  assign h3 = v3 & we3 & m3;
  assign h4 = v4 & we4 & m4;

  assign f3 = ~h2 & h3 & (FWD_S3_MUX | (FWD_S3_PASS & ~sl3));
  assign f4 = ~h2 & ~h3 & h4 & FWD_S4;

  assign stall = in_valid & rd_en & (h2 | h3 | h4) & ~f3 & ~f4;

  assign rd_mem = (DEPTH == 1) ? mem[0] : mem[rd_idx];
  always_comb begin
    if (!rd_en)  rd_val = '0;
    else if (f3) rd_val = FWD_S3_MUX ? wd3 : x3;
    else if (f4) rd_val = wd4;
    else         rd_val = rd_mem;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; wq2 <= 1'b0; cd2 <= 1'b0; sl2 <= 1'b0;
      idx2 <= '0; r2 <= '0; k2 <= '0;
      v3 <= 1'b0; wq3 <= 1'b0; cd3 <= 1'b0; sl3 <= 1'b0;
      idx3 <= '0; x3 <= '0;
      v4 <= 1'b0; we4 <= 1'b0; idx4 <= '0; wd4 <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      v2   <= in_valid & ~stall;
      wq2  <= in_valid & ~stall & wr_req;
      cd2  <= cond;
      sl2  <= sel;
      idx2 <= wr_idx;
      r2   <= rd_val;
      k2   <= k;

      v3   <= v2;
      wq3  <= wq2;
      cd3  <= cd2;
      sl3  <= sl2;
      idx3 <= idx2;
      x3   <= r2 + k2;

      v4   <= v3;
      we4  <= v3 & we3;
      idx4 <= idx3;
      wd4  <= wd3;

      if (v4 && we4) begin
        if (DEPTH == 1) mem[0] <= wd4;
        else            mem[idx4] <= wd4;
      end
    end
  end

  assign cm_valid = v4;
  assign cm_we    = we4;
  assign cm_idx   = idx4;
  assign cm_data  = wd4;
endmodule

// File: rtl/raw_fwd_pipe_chk.sv
module raw_fwd_pipe_chk #(
  parameter int IW = 2,
  parameter int DEPTH = 4,
  parameter bit FWD_S4 = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          rd_en,
  input logic [IW-1:0] rd_idx,
  input logic          stall,
  input logic          cm_valid,
  input logic          cm_we,
  input logic [IW-1:0] cm_idx,
  input logic          v2,
  input logic [IW-1:0] idx2,
  input logic          v3,
  input logic          we3,
  input logic [IW-1:0] idx3
);
  logic hit2, hit3, hit4;
  assign hit2 = v2 & ((DEPTH == 1) || (idx2 == rd_idx));
  assign hit3 = v3 & we3 & ((DEPTH == 1) || (idx3 == rd_idx));
  assign hit4 = cm_valid & cm_we & ((DEPTH == 1) || (cm_idx == rd_idx));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !cm_valid);

  // R3
  no_read_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && rd_en) |-> !stall);

  // R5
  young_writer_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rd_en && hit2) |-> stall);

  // R7
  s4_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (FWD_S4 && in_valid && rd_en && hit4 && !hit2 && !hit3) |-> !stall);

  // R9
  bubble_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !v2);
endmodule

bind raw_fwd_pipe raw_fwd_pipe_chk #(.IW(IW), .DEPTH(DEPTH), .FWD_S4(FWD_S4)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rd_en(rd_en), .rd_idx(rd_idx),
  .stall(stall), .cm_valid(cm_valid), .cm_we(cm_we), .cm_idx(cm_idx),
  .v2(v2), .idx2(idx2), .v3(v3), .we3(we3), .idx3(idx3)
);

// File: tb/sim_raw_fwd_pipe.sv
`timescale 1ns/1ps
module sim_raw_fwd_pipe;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int IW = 2;
  localparam bit F4 = 1'b1;
  localparam bit F3M = 1'b0;
  localparam bit F3P = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, rd_en = 1'b0, wr_req = 1'b0, cond = 1'b0, sel = 1'b0;
  logic [IW-1:0] rd_idx = '0, wr_idx = '0;
  logic [DW-1:0] k = '0;
  logic stall, cm_valid, cm_we;
  logic [IW-1:0] cm_idx;
  logic [DW-1:0] cm_data;

  always #10 clk = ~clk;

  raw_fwd_pipe #(.DW(DW), .DEPTH(DEPTH), .FWD_S4(F4), .FWD_S3_MUX(F3M), .FWD_S3_PASS(F3P)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rd_en(rd_en), .rd_idx(rd_idx),
    .wr_req(wr_req), .wr_idx(wr_idx), .cond(cond), .sel(sel), .k(k),
    .stall(stall), .cm_valid(cm_valid), .cm_we(cm_we), .cm_idx(cm_idx), .cm_data(cm_data));

  typedef struct packed {
    logic v; logic we; logic [IW-1:0] idx; logic sel; logic [DW-1:0] wd; logic bub;
  } slot_t;

  slot_t s2, s3, s4, pend;
  logic [DW-1:0] ref_mem [DEPTH];
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit mt(input slot_t s);
    return (DEPTH == 1) || (s.idx == rd_idx);
  endfunction

  function automatic bit exp_stall();
    bit h2, h3, h4, f3, f4;
    h2 = s2.v & mt(s2);
    h3 = s3.v & s3.we & mt(s3);
    h4 = s4.v & s4.we & mt(s4);
    f3 = !h2 && h3 && (F3M || (F3P && !s3.sel));
    f4 = !h2 && !h3 && h4 && F4;
    return in_valid && rd_en && (h2 || h3 || h4) && !f3 && !f4;
  endfunction

  function automatic string stall_tag();
    bit h2, h3, h4;
    h2 = s2.v & mt(s2);
    h3 = s3.v & s3.we & mt(s3);
    h4 = s4.v & s4.we & mt(s4);
    if (!in_valid || !rd_en) return "R3";
    if (h2 && (h3 || h4)) return "R6";
    if (h2) return "R5";
    if (h3) return "R8";
    if (h4) return "R7";
    if (s2.v || (s3.v && s3.we) || (s4.v && s4.we)) return "R4";
    return "R10";
  endfunction

  task automatic cycle(output bit acc);
    bit e;
    #2;
    e = exp_stall();
    chk(stall == e, stall_tag(), "stall", int'(stall), int'(e));
    if (s4.bub) chk(cm_valid == 1'b0, "R9", "bubble cm_valid", int'(cm_valid), 0);
    else chk(cm_valid == s4.v, "R2", "cm_valid", int'(cm_valid), int'(s4.v));
    if (s4.v) begin
      chk(cm_we == s4.we, "R2", "cm_we", int'(cm_we), int'(s4.we));
      if (s4.we) begin
        chk(cm_idx == s4.idx, "R2", "cm_idx", int'(cm_idx), int'(s4.idx));
        chk(cm_data == s4.wd, "R2", "cm_data", int'(cm_data), int'(s4.wd));
      end
    end
    acc = in_valid && !e;
    @(posedge clk);
    s4 = s3;
    s3 = s2;
    if (acc) s2 = pend;
    else begin
      s2 = '0;
      s2.bub = in_valid;
    end
    @(negedge clk);
  endtask

  task automatic send(input bit re, input int ri, input bit wq, input int wi,
                      input bit cd, input bit sl, input int kk);
    logic [DW-1:0] r, x, wd;
    bit w, acc;
    int tries;
    r = re ? ref_mem[ri] : '0;
    x = r + DW'(kk);
    w = wq && (!cd || x != '0);
    wd = sl ? {x[DW-2:0], x[DW-1]} : x;
    if (w) ref_mem[wi] = wd;
    pend = '0;
    pend.v = 1'b1; pend.we = w; pend.idx = IW'(wi); pend.sel = sl; pend.wd = wd;
    in_valid = 1'b1; rd_en = re; rd_idx = IW'(ri); wr_req = wq; wr_idx = IW'(wi);
    cond = cd; sel = sl; k = DW'(kk);
    tries = 0;
    acc = 0;
    while (!acc) begin
      cycle(acc);
      tries++;
      if (tries > 20 && !acc) begin
        chk(1'b0, "R10", "watchdog stall stuck", tries, 20);
        acc = 1;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic idle();
    bit acc;
    in_valid = 1'b0;
    rd_en = 1'($urandom_range(0, 1));
    cycle(acc);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "R10", "watchdog timeout", 0, 1);
    summary();
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    s2 = '0; s3 = '0; s4 = '0; pend = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(cm_valid == 1'b0, "R1", "reset cm_valid", int'(cm_valid), 0);
    chk(stall == 1'b0, "R1", "reset stall", int'(stall), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(cm_valid == 1'b0, "R1", "post-reset cm_valid", int'(cm_valid), 0);
    @(negedge clk);

    // R1: every entry reads back as zero
    for (int i = 0; i < DEPTH; i++) send(1, i, 1, i, 0, 0, 0);
    repeat (4) idle();
    // R5: stage-2 writer that turns out not to write still stalls
    send(0, 0, 1, 1, 1, 0, 0);
    send(1, 1, 1, 2, 0, 0, 5);
    // R8: pass leg forwarded, rotate leg stalls
    send(0, 0, 1, 2, 0, 0, 9);
    send(1, 2, 1, 3, 0, 0, 1);
    send(0, 0, 1, 3, 0, 1, 8'h81);
    send(1, 3, 1, 0, 0, 0, 2);
    // R7: stage-4 forward after two unrelated transactions
    send(0, 0, 1, 0, 0, 0, 33);
    send(0, 0, 1, 1, 0, 0, 4);
    send(0, 0, 0, 2, 0, 0, 0);
    send(1, 0, 1, 3, 0, 0, 1);
    // R6: two writers to one entry in flight
    send(0, 0, 1, 1, 0, 0, 10);
    send(0, 0, 1, 1, 0, 0, 20);
    send(1, 1, 1, 2, 0, 0, 3);
    // R4: different index does not stall
    send(0, 0, 1, 0, 0, 0, 7);
    send(1, 3, 1, 2, 0, 0, 1);
    repeat (4) idle();

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 9) == 0) idle();
      else send(1'($urandom_range(0, 3) != 0), int'($urandom_range(0, DEPTH - 1)),
                1'($urandom_range(0, 3) != 0), int'($urandom_range(0, DEPTH - 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 3)));
    end
    repeat (5) idle();
    summary();
  end
endmodule